// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block selects one interrupt source out of a parameterised set (22 by default) and requests a vector call from a small 8-bit CPU core. A source takes part in arbitration only when three things are set together: its pending flag, its enable bit and a global enable. Each source also has a priority bit that puts it in the low or the high level. The block keeps a two-bit in-service record, so a high-level routine can interrupt a low-level one and nothing can interrupt a high-level routine.

The CPU reports four events to the block: it accepts a request (acknowledge), it executes a return from interrupt, it completes an instruction, and it is stalled by a flash write or erase. After every return the block waits for one completed instruction before it raises another request. No request is raised while the stall is asserted. The vector address is 0x0003 plus eight times the winning source's fixed index. The request, the vector and the level are registered, and they hold their values until the CPU acknowledges.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Source i is eligible only when `pend_i[i]`, `en_i[i]` and `gie_i` are all 1. If the enable bit or `gie_i` is 0, no request is raised for that source. Setting the missing enable later makes the source eligible again.
- R2: A slot set in the reserved mask is never selected, even when it is pending and enabled. The default mask reserves index 20.
- R3: Detection takes one clock. If an eligible, unblocked request is present before a rising edge, and no request is being held, `svc_req_o` is 1 after that edge.
- R4: `vec_o` equals 0x0003 + 8 × index. For example, index 15 gives 0x007B and index 21 gives 0x00AB.
- R5: `prio_i[i]` = 1 places source i in the high level, and 0 places it in the low level. When both levels request in the same cycle, the high level wins. `svc_lvl_o` reports the level of the request: 1 for high, 0 for low.
- R6: Among requests of the same level, the source with the lowest index wins.
- R7: While `insvc_o[0]` (low in service) is set, low-level requests are held off. A high-level request still raises `svc_req_o`.
- R8: While `insvc_o[1]` (high in service) is set, no request is raised.
- R9: `insvc_o` is 0 after reset. An `ack_i` that arrives while `svc_req_o` is 1 sets the `insvc_o` bit of the level on `svc_lvl_o` and clears `svc_req_o`. A `reti_i` pulse clears the highest set bit of `insvc_o`.
- R10: After a `reti_i` pulse, no request is raised until one `instr_done_i` pulse has been seen.
- R11: While `stall_i` is 1, `svc_req_o` is not raised and requests stay pending. The request is raised after the stall is released.
- R12: Once `svc_req_o` is 1, it stays 1 and `vec_o` and `svc_lvl_o` keep their values until `ack_i`. This holds even when a request of higher priority arrives in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pend_i | input | NUM_SRC | Pending flags of the sources |
| en_i | input | NUM_SRC | Enable bit for each source |
| prio_i | input | NUM_SRC | Level for each source: 1 = high, 0 = low |
| gie_i | input | 1 | Global enable for all requests |
| stall_i | input | 1 | CPU stalled by a flash operation |
| ack_i | input | 1 | CPU accepts the request at an instruction boundary |
| reti_i | input | 1 | Return from interrupt executed (one-cycle pulse) |
| instr_done_i | input | 1 | One instruction completed (one-cycle pulse) |
| svc_req_o | output | 1 | Request to the CPU for a vector call |
| vec_o | output | 16 | Vector address of the request |
| svc_lvl_o | output | 1 | Level of the request: 1 = high |
| insvc_o | output | 2 | In-service record: bit 0 = low, bit 1 = high |

## Verification
The bench drives a single source, two sources of the same level at once, and a high and a low source at once. These three patterns separate the index tie-break from the level priority. Some requests arrive while a routine is in service, with the in-service record at low, high and both. These show whether the preemption rules depend on the in-service record or only on the incoming level. Sources that are reserved, disabled or globally masked, and requests made during a stall or in the window after a return, should produce no request at the port. The bench checks that they do not.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int IDX_W      = 8;
    localparam int VEC_W      = 16;
    localparam int VEC_BASE   = 3;
    localparam int VEC_SHIFT  = 3;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } pick_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        lvl_e             lvl;
    } cand_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } insvc_t;

    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        logic [VEC_W-1:0] wide;
        wide = VEC_W'(idx) << VEC_SHIFT;
        return wide + VEC_W'(VEC_BASE);
    endfunction

endpackage

// File: rtl/irq_req_gate.sv
module irq_req_gate
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 22,
    parameter logic [NUM_SRC-1:0] RSVD_MASK = '0
) (
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic [NUM_SRC-1:0] prio_i,
    input  logic               gie_i,
    output logic [NUM_SRC-1:0] req_hi_o,
    output logic [NUM_SRC-1:0] req_lo_o
);

    logic [NUM_SRC-1:0] live;

    always_comb begin
        live     = pend_i & en_i & ~RSVD_MASK & {NUM_SRC{gie_i}};
        req_hi_o = live & prio_i;
        req_lo_o = live & ~prio_i;
    end

endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 22
) (
    input  logic [NUM_SRC-1:0] req_i,
    output pick_t              pick_o
);

    always_comb begin
        pick_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                pick_o.valid = 1'b1;
                pick_o.idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_nest_track.sv
module irq_nest_track
    import irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   grant_i,
    input  lvl_e   grant_lvl_i,
    input  logic   reti_i,
    output insvc_t insvc_o
);

    insvc_t cur_q, nxt;

    always_comb begin
        nxt = cur_q;
        if (reti_i) begin
            if (nxt.hi) nxt.hi = 1'b0;
            else        nxt.lo = 1'b0;
        end
        if (grant_i) begin
            if (grant_lvl_i == LVL_HIGH) nxt.hi = 1'b1;
            else                         nxt.lo = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt;
    end

    assign insvc_o = cur_q;

endmodule

// File: rtl/irq_issue.sv
module irq_issue
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cand_t            cand_i,
    input  logic             stall_i,
    input  logic             ack_i,
    input  logic             reti_i,
    input  logic             instr_done_i,
    output logic             req_o,
    output logic [VEC_W-1:0] vec_o,
    output lvl_e             lvl_o
);

    logic             req_q;
    logic             guard_q;
    logic [VEC_W-1:0] vec_q;
    lvl_e             lvl_q;
    logic             may_raise;

    assign may_raise = cand_i.valid && !stall_i && !guard_q && !reti_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= 1'b0;
            guard_q <= 1'b0;
            vec_q   <= '0;
            lvl_q   <= LVL_LOW;
        end else begin
            if (reti_i)            guard_q <= 1'b1;
            else if (instr_done_i) guard_q <= 1'b0;

            if (req_q) begin
                if (ack_i) req_q <= 1'b0;
            end else if (may_raise) begin
                req_q <= 1'b1;
                vec_q <= vec_of(cand_i.idx);
                lvl_q <= cand_i.lvl;
            end
        end
    end

    assign req_o = req_q;
    assign vec_o = vec_q;
    assign lvl_o = lvl_q;

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 22,
    parameter logic [NUM_SRC-1:0] RSVD_MASK = NUM_SRC'(32'h0010_0000)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic [NUM_SRC-1:0] prio_i,
    input  logic               gie_i,
    input  logic               stall_i,
    input  logic               ack_i,
    input  logic               reti_i,
    input  logic               instr_done_i,
    output logic               svc_req_o,
    output logic [15:0]        vec_o,
    output logic               svc_lvl_o,
    output logic [1:0]         insvc_o
);

    localparam int NUM_LVL = 2;

    logic [NUM_SRC-1:0] lvl_req [NUM_LVL];
    pick_t              lvl_pick [NUM_LVL];
    insvc_t             insvc;
    cand_t              cand;
    logic               req_q;
    lvl_e               lvl_q;
    logic [VEC_W-1:0]   vec_q;

    irq_req_gate #(.NUM_SRC(NUM_SRC), .RSVD_MASK(RSVD_MASK)) u_gate (
        .pend_i   (pend_i),
        .en_i     (en_i),
        .prio_i   (prio_i),
        .gie_i    (gie_i),
        .req_hi_o (lvl_req[LVL_HIGH]),
        .req_lo_o (lvl_req[LVL_LOW])
    );

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        irq_level_pick #(.NUM_SRC(NUM_SRC)) u_pick (
            .req_i  (lvl_req[g]),
            .pick_o (lvl_pick[g])
        );
    end

    always_comb begin
        cand = '0;
        if (lvl_pick[LVL_HIGH].valid && !insvc.hi) begin
            cand.valid = 1'b1;
            cand.idx   = lvl_pick[LVL_HIGH].idx;
            cand.lvl   = LVL_HIGH;
        end else if (lvl_pick[LVL_LOW].valid && !insvc.hi && !insvc.lo) begin
            cand.valid = 1'b1;
            cand.idx   = lvl_pick[LVL_LOW].idx;
            cand.lvl   = LVL_LOW;
        end
    end

    irq_nest_track u_nest (
        .clk         (clk),
        .rst         (rst),
        .grant_i     (ack_i && req_q),
        .grant_lvl_i (lvl_q),
        .reti_i      (reti_i),
        .insvc_o     (insvc)
    );

    irq_issue u_issue (
        .clk          (clk),
        .rst          (rst),
        .cand_i       (cand),
        .stall_i      (stall_i),
        .ack_i        (ack_i),
        .reti_i       (reti_i),
        .instr_done_i (instr_done_i),
        .req_o        (req_q),
        .vec_o        (vec_q),
        .lvl_o        (lvl_q)
    );

    assign svc_req_o = req_q;
    assign vec_o     = vec_q;
    assign svc_lvl_o = lvl_q;
    assign insvc_o   = insvc;

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        stall_i,
    input logic        ack_i,
    input logic        reti_i,
    input logic        svc_req_o,
    input logic [15:0] vec_o,
    input logic        svc_lvl_o,
    input logic [1:0]  insvc_o
);

    assert_hold_stable_R12: assert property (@(posedge clk) disable iff (rst)
        svc_req_o && !ack_i |=> svc_req_o && $stable(vec_o) && $stable(svc_lvl_o));

    assert_stall_blocks_R11: assert property (@(posedge clk) disable iff (rst)
        stall_i && !svc_req_o |=> !svc_req_o);

    assert_high_blocks_all_R8: assert property (@(posedge clk) disable iff (rst)
        insvc_o[1] |-> !svc_req_o);

    assert_low_needs_idle_R7: assert property (@(posedge clk) disable iff (rst)
        svc_req_o && !svc_lvl_o |-> insvc_o == 2'b00);

    assert_reti_guard_R10: assert property (@(posedge clk) disable iff (rst)
        reti_i && !svc_req_o |=> !svc_req_o);

    assert_vec_form_R4: assert property (@(posedge clk) disable iff (rst)
        svc_req_o |-> vec_o[2:0] == 3'b011);

    assert_ack_sets_R9: assert property (@(posedge clk) disable iff (rst)
        svc_req_o && ack_i && !reti_i |=> !svc_req_o && insvc_o[$past(svc_lvl_o)]);

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .stall_i   (stall_i),
    .ack_i     (ack_i),
    .reti_i    (reti_i),
    .svc_req_o (svc_req_o),
    .vec_o     (vec_o),
    .svc_lvl_o (svc_lvl_o),
    .insvc_o   (insvc_o)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;

    localparam int N = 22;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  pend_i = '0;
    logic [N-1:0]  en_i = '0;
    logic [N-1:0]  prio_i = '0;
    logic          gie_i = 1'b0;
    logic          stall_i = 1'b0;
    logic          ack_i = 1'b0;
    logic          reti_i = 1'b0;
    logic          instr_done_i = 1'b0;
    logic          svc_req_o;
    logic [15:0]   vec_o;
    logic          svc_lvl_o;
    logic [1:0]    insvc_o;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [15:0] vec;
        logic        lvl;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    logic req_prev = 1'b0;

    always #2 clk = ~clk;

    irq_prio_ctrl dut_i (
        .clk          (clk),
        .rst          (rst),
        .pend_i       (pend_i),
        .en_i         (en_i),
        .prio_i       (prio_i),
        .gie_i        (gie_i),
        .stall_i      (stall_i),
        .ack_i        (ack_i),
        .reti_i       (reti_i),
        .instr_done_i (instr_done_i),
        .svc_req_o    (svc_req_o),
        .vec_o        (vec_o),
        .svc_lvl_o    (svc_lvl_o),
        .insvc_o      (insvc_o)
    );

    function automatic logic [15:0] exp_vec(input int idx);
        return 16'(3 + 8 * idx);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic expect_vec(input int idx, input logic lvl, input string tag);
        exp_t e;
        e.vec = exp_vec(idx);
        e.lvl = lvl;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compares each newly raised request with the scoreboard
    always @(negedge clk) begin
        if (rst) begin
            req_prev = 1'b0;
        end else begin
            if (svc_req_o && !req_prev) begin
                if (exp_q.size() == 0) begin
                    total++;
                    bad++;
                    $display("FAIL unexpected request actual=%h expected=none", vec_o);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check({e.tag, " vec"}, 32'(vec_o), 32'(e.vec));
                    check({e.tag, " lvl"}, 32'(svc_lvl_o), 32'(e.lvl));
                end
            end
            req_prev = svc_req_o;
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic src(input int idx, input logic p, input logic e, input logic hi);
        pend_i[idx] = p;
        en_i[idx]   = e;
        prio_i[idx] = hi;
    endtask

    task automatic do_ack();
        ack_i = 1'b1;
        cyc(1);
        ack_i = 1'b0;
    endtask

    task automatic do_ret();
        reti_i = 1'b1;
        cyc(1);
        reti_i = 1'b0;
        cyc(2);
        instr_done_i = 1'b1;
        cyc(1);
        instr_done_i = 1'b0;
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        gie_i = 1'b1;
        cyc(1);
        check("R9 reset insvc", 32'(insvc_o), 32'h0);
        check("R9 reset req", 32'(svc_req_o), 32'h0);

        // R3 R4: single low source 15, one-clock detection
        expect_vec(15, 1'b0, "R4 idx15");
        src(15, 1, 1, 0);
        cyc(1);
        check("R3 one clock detect", 32'(svc_req_o), 32'h1);
        check("R4 vec 15", 32'(vec_o), 32'h007B);
        // R12: a high request arrives before ack, output held
        src(21, 1, 1, 1);
        cyc(2);
        check("R12 held vec", 32'(vec_o), 32'h007B);
        check("R12 held lvl", 32'(svc_lvl_o), 32'h0);
        expect_vec(21, 1'b1, "R7 preempt idx21");
        do_ack();
        check("R9 ack low", 32'(insvc_o), 32'h1);
        src(15, 0, 1, 0);
        cyc(1);
        check("R4 vec 21", 32'(vec_o), 32'h00AB);
        do_ack();
        check("R9 ack high nests", 32'(insvc_o), 32'h3);
        src(21, 0, 1, 1);
        // R8: high pending while high in service
        src(2, 1, 1, 1);
        src(3, 1, 1, 0);
        cyc(4);
        check("R8 blocked under high", 32'(svc_req_o), 32'h0);
        // R10: return from high; high 2 eligible but guarded
        expect_vec(2, 1'b1, "R10 after guard idx2");
        reti_i = 1'b1;
        cyc(1);
        reti_i = 1'b0;
        check("R9 reti clears high", 32'(insvc_o), 32'h1);
        cyc(3);
        check("R10 guard holds", 32'(svc_req_o), 32'h0);
        instr_done_i = 1'b1;
        cyc(1);
        instr_done_i = 1'b0;
        cyc(2);
        check("R10 released", 32'(svc_req_o), 32'h1);
        do_ack();
        src(2, 0, 1, 1);
        do_ret();
        // R7: low 3 pending while low in service
        cyc(3);
        check("R7 low blocked under low", 32'(svc_req_o), 32'h0);
        expect_vec(3, 1'b0, "R7 low after return idx3");
        do_ret();
        check("R9 all returned", 32'(insvc_o), 32'h0);
        cyc(2);
        do_ack();
        src(3, 0, 1, 0);
        do_ret();

        // R6: same level tie
        expect_vec(5, 1'b0, "R6 tie idx5");
        src(5, 1, 1, 0);
        src(9, 1, 1, 0);
        cyc(2);
        do_ack();
        src(5, 0, 1, 0);
        src(9, 0, 1, 0);
        do_ret();

        // R5: high beats low in same cycle
        expect_vec(12, 1'b1, "R5 high wins idx12");
        src(1, 1, 1, 0);
        src(12, 1, 1, 1);
        cyc(2);
        do_ack();
        src(12, 0, 1, 1);
        src(1, 0, 1, 0);
        do_ret();

        // R1: disabled source and global mask
        src(7, 1, 0, 0);
        cyc(3);
        check("R1 enable clear", 32'(svc_req_o), 32'h0);
        gie_i = 1'b0;
        src(7, 1, 1, 0);
        cyc(3);
        check("R1 global clear", 32'(svc_req_o), 32'h0);
        expect_vec(7, 1'b0, "R1 global set idx7");
        gie_i = 1'b1;
        cyc(2);
        do_ack();
        src(7, 0, 1, 0);
        do_ret();

        // R11: stall
        stall_i = 1'b1;
        src(10, 1, 1, 1);
        cyc(4);
        check("R11 stall blocks", 32'(svc_req_o), 32'h0);
        expect_vec(10, 1'b1, "R11 after stall idx10");
        stall_i = 1'b0;
        cyc(1);
        check("R11 raised after stall", 32'(svc_req_o), 32'h1);
        do_ack();
        src(10, 0, 1, 1);
        do_ret();

        // R2: reserved slot 20
        src(20, 1, 1, 1);
        cyc(4);
        check("R2 reserved never", 32'(svc_req_o), 32'h0);
        src(20, 0, 0, 0);
        cyc(2);

        check("scoreboard drained", 32'(exp_q.size()), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule